// File: doc/BRIEF.md
# Pixel Serializer with Character Attributes

This block converts a stream of fetched display bytes into one colour index per pixel cycle. Each bitmap byte holds eight one-bit pixels, sent out most significant bit first, and each pixel can be repeated for one, two or three cycles. Repeating pixels stretches a narrow line across the full 640-cycle active width. For example, 26 columns at triple width fill 624 cycles and leave 16 cycles blank.

When there are fewer than 80 bitmap bytes per line, the memory slots between bitmap fetches can carry attribute bytes. An attribute byte gives a foreground colour and a background colour for the next character column, so the first column slot of a line carries no pixels. Attributes are fetched only on the first pixel row of a character row. They go into a line buffer and are reused on the remaining rows. In shared mode, one attribute covers two adjacent columns, which halves the attribute traffic. The upstream fetch engine tags each byte as bitmap or attribute, marks line starts, and supplies the pixel row within the character. Memory addressing is handled upstream.

Top module: `attr_pixel_serializer`

## Requirements
- R1: While reset is held and after it is released, `pix_active` is 0 and `pix_colour` is the blank value 4'h0.
- R2: A bitmap byte (`in_valid`=1, `in_tag`=0) is taken at a clock edge. Its bit 7 is shown from that edge onward, followed by bits 6 down to 0.
- R3: `cfg_scale` sets how many cycles each pixel is held: 0 gives x1, 1 gives x2 and 2 gives x3. A byte lasts 8×scale cycles and then `pix_active` falls, unless the next bitmap byte is taken at the edge that ends the last pixel, in which case output continues without a gap.
- R4: With `cfg_attr_en`=0, a set bit shows colour 4'hF and a clear bit shows 4'h8. Blank cycles show 4'h0 with `pix_active`=0.
- R5: `line_start` blanks the output from the next cycle, abandons the byte in progress and restarts the column and attribute counts. A byte presented in the same cycle as `line_start` is dropped.
- R6: With `cfg_attr_en`=1, a byte tagged `in_tag`=1 is an attribute. Its bits 7:4 are the colour of set pixels and bits 3:0 the colour of clear pixels.
- R7: On a line with `char_row`=0, the k-th attribute byte of the line is stored in buffer entry k. In unshared mode, the k-th bitmap column of the line uses entry k. Entries are stored before the column that uses them, so the output stays blank while the leading attribute is fetched.
- R8: On a line with `char_row`≠0, attribute bytes change nothing, and each column takes its colours from the entries stored on the last first-row line.
- R9: With `cfg_attr_shared`=1, bitmap column c uses buffer entry c/2 (rounded down), so one attribute colours two adjacent columns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| line_start | input | 1 | One-cycle pulse at the start of each line's fetch sequence |
| char_row | input | 3 | Pixel row within the current character row |
| cfg_scale | input | 2 | Pixel repeat code: 0 = x1, 1 = x2, 2 = x3 |
| cfg_attr_en | input | 1 | Use attribute colours instead of the fixed pair |
| cfg_attr_shared | input | 1 | One attribute covers two columns |
| in_valid | input | 1 | A fetched byte is present |
| in_tag | input | 1 | 0 = bitmap byte, 1 = attribute byte |
| in_data | input | 8 | Fetched byte |
| pix_colour | output | 4 | Colour index for this cycle |
| pix_active | output | 1 | A pixel is being shown this cycle |

## Verification
The assertions assume the following about the upstream fetcher:
- A new bitmap byte arrives only when no byte is in progress, or exactly at the edge that ends the last pixel.
- Configuration inputs stay constant within a line.
- A line uses no more than 80 fetches.
- In attribute mode, columns never address beyond the 40-entry buffer.

The stimulus respects all of these. Each bitmap byte is issued either from idle or at the final pixel slot of the previous byte. Attribute bytes are placed in the middle of a byte's output, in the spare slot, so they never collide with a bitmap reload. Configuration changes only between lines. Each line uses only a few columns.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

   typedef enum logic {
      TAG_BITMAP = 1'b0,
      TAG_ATTR   = 1'b1
   } byte_tag_e;

   localparam logic [1:0] SCALE_X1 = 2'd0;
   localparam logic [1:0] SCALE_X2 = 2'd1;
   localparam logic [1:0] SCALE_X3 = 2'd2;

   // last hold count for a pixel; unused code falls back to x1
   function automatic logic [1:0] hold_last_of(input logic [1:0] code);
      case (code)
         SCALE_X2: hold_last_of = 2'd1;
         SCALE_X3: hold_last_of = 2'd2;
         default:  hold_last_of = 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/pxs_shifter.sv
module pxs_shifter #(
   parameter int BYTE_W = 8,
   parameter int HOLD_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_data,
   input  logic [HOLD_W-1:0] hold_last,
   output logic              active,
   output logic              out_bit,
   output logic              hold_end,
   output logic              at_last
);
   localparam int BIT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

   logic [BYTE_W-1:0] sh_q;
   logic [HOLD_W-1:0] hold_q;
   logic [BIT_W-1:0]  cnt_q;
   logic              act_q;

   assign active   = act_q;
   assign out_bit  = sh_q[BYTE_W-1];
   assign hold_end = (hold_q == hold_last);
   assign at_last  = act_q && hold_end && (cnt_q == LAST_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         hold_q <= '0;
         cnt_q  <= '0;
         act_q  <= 1'b0;
      end else if (clear) begin
         act_q  <= 1'b0;
         hold_q <= '0;
         cnt_q  <= '0;
      end else if (load) begin
         sh_q   <= load_data;
         act_q  <= 1'b1;
         hold_q <= '0;
         cnt_q  <= '0;
      end else if (act_q) begin
         if (hold_end) begin
            hold_q <= '0;
            if (cnt_q == LAST_BIT) begin
               act_q <= 1'b0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
               sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
            end
         end else begin
            hold_q <= hold_q + 1'b1;
         end
      end
   end

   // upstream reloads only from idle or on the final pixel slot
   p_load_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clear && act_q) |-> at_last);

   p_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (at_last && !load && !clear) |=> !act_q);

endmodule

// File: rtl/pxs_attr_buf.sv
module pxs_attr_buf #(
   parameter int DEPTH  = 40,
   parameter int DATA_W = 8,
   parameter int IDX_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (IDX_W < ADDR_W) begin : g_bad_idx
      $error("pxs_attr_buf: IDX_W too narrow for DEPTH");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en && (int'(wr_idx) < DEPTH)) begin
         mem[wr_idx[ADDR_W-1:0]] <= wr_data;
      end
   end

   always_comb begin
      if (int'(rd_idx) < DEPTH) rd_data = mem[rd_idx[ADDR_W-1:0]];
      else                      rd_data = '0;
   end

endmodule

// File: rtl/pxs_colour_sel.sv
module pxs_colour_sel #(
   parameter int               COLOUR_W = 4,
   parameter logic [COLOUR_W-1:0] FG_PLAIN = '1,
   parameter logic [COLOUR_W-1:0] BG_PLAIN = '0,
   parameter logic [COLOUR_W-1:0] BLANK    = '0
) (
   input  logic                  active,
   input  logic                  pix_bit,
   input  logic                  attr_mode,
   input  logic [2*COLOUR_W-1:0] attr,
   output logic [COLOUR_W-1:0]   colour
);
   always_comb begin
      if (!active)        colour = BLANK;
      else if (attr_mode) colour = pix_bit ? attr[2*COLOUR_W-1:COLOUR_W] : attr[COLOUR_W-1:0];
      else                colour = pix_bit ? FG_PLAIN : BG_PLAIN;
   end
endmodule

// File: rtl/attr_pixel_serializer.sv
module attr_pixel_serializer
   import pxs_pkg::*;
#(
   parameter int          COLOUR_W     = 4,
   parameter int          ROW_W        = 3,
   parameter int          BUF_DEPTH    = 40,
   parameter int          MAX_FETCH    = 80,
   parameter bit          ATTR_SUPPORT = 1'b1,
   parameter logic [COLOUR_W-1:0] FG_PLAIN = 4'hF,
   parameter logic [COLOUR_W-1:0] BG_PLAIN = 4'h8,
   parameter logic [COLOUR_W-1:0] BLANK    = 4'h0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  line_start,
   input  logic [ROW_W-1:0]      char_row,
   input  logic [1:0]            cfg_scale,
   input  logic                  cfg_attr_en,
   input  logic                  cfg_attr_shared,
   input  logic                  in_valid,
   input  logic                  in_tag,
   input  logic [2*COLOUR_W-1:0] in_data,
   output logic [COLOUR_W-1:0]   pix_colour,
   output logic                  pix_active
);
   localparam int BYTE_W = 2 * COLOUR_W;
   localparam int CNT_W  = $clog2(MAX_FETCH + 2);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_FETCH + 1);

   if (BUF_DEPTH < 1 || BUF_DEPTH > MAX_FETCH) begin : g_bad_depth
      $error("attr_pixel_serializer: BUF_DEPTH out of range");
   end
   if (ROW_W < 1) begin : g_bad_row
      $error("attr_pixel_serializer: ROW_W must be positive");
   end

   // ---------------- byte classification ----------------
   logic take, load, attr_seen, first_row;
   assign take      = in_valid && !line_start;
   assign load      = take && (in_tag == TAG_BITMAP);
   assign attr_seen = take && (in_tag == TAG_ATTR);
   assign first_row = (char_row == '0);

   // ---------------- per-line counters ----------------
   logic [CNT_W-1:0] col_q, attr_q, fetch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q   <= '0;
         attr_q  <= '0;
         fetch_q <= '0;
      end else if (line_start) begin
         col_q   <= '0;
         attr_q  <= '0;
         fetch_q <= '0;
      end else begin
         if (load && col_q != CNT_SAT) col_q <= col_q + 1'b1;
         if (attr_seen && cfg_attr_en && first_row && attr_q != CNT_SAT)
            attr_q <= attr_q + 1'b1;
         if (take && fetch_q != CNT_SAT) fetch_q <= fetch_q + 1'b1;
      end
   end

   // ---------------- attribute source ----------------
   logic [CNT_W-1:0]  rd_idx;
   logic [BYTE_W-1:0] attr_rd;
   logic [BYTE_W-1:0] cur_attr_q;
   logic              cur_mode_q;

   assign rd_idx = cfg_attr_shared ? (col_q >> 1) : col_q;

   if (ATTR_SUPPORT) begin : g_attr
      logic attr_wr;
      assign attr_wr = attr_seen && cfg_attr_en && first_row;
      pxs_attr_buf #(
         .DEPTH  (BUF_DEPTH),
         .DATA_W (BYTE_W),
         .IDX_W  (CNT_W)
      ) i_buf (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (attr_wr),
         .wr_idx  (attr_q),
         .wr_data (in_data),
         .rd_idx  (rd_idx),
         .rd_data (attr_rd)
      );
   end else begin : g_plain
      assign attr_rd = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_attr_q <= '0;
         cur_mode_q <= 1'b0;
      end else if (load) begin
         cur_mode_q <= ATTR_SUPPORT && cfg_attr_en;
         cur_attr_q <= (ATTR_SUPPORT && cfg_attr_en) ? attr_rd : '0;
      end
   end

   // ---------------- serializer ----------------
   logic sh_bit, hold_end, at_last;

   pxs_shifter #(
      .BYTE_W (BYTE_W),
      .HOLD_W (2)
   ) i_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (line_start),
      .load      (load),
      .load_data (in_data),
      .hold_last (hold_last_of(cfg_scale)),
      .active    (pix_active),
      .out_bit   (sh_bit),
      .hold_end  (hold_end),
      .at_last   (at_last)
   );

   pxs_colour_sel #(
      .COLOUR_W (COLOUR_W),
      .FG_PLAIN (FG_PLAIN),
      .BG_PLAIN (BG_PLAIN),
      .BLANK    (BLANK)
   ) i_colour (
      .active    (pix_active),
      .pix_bit   (sh_bit),
      .attr_mode (cur_mode_q),
      .attr      (cur_attr_q),
      .colour    (pix_colour)
   );

   // ---------------- assertions ----------------
   p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_active && !hold_end && !load && !line_start) |=>
         (pix_active && $stable(pix_colour)));

   p_line_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |=> !pix_active);

   p_fetch_budget_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_q <= CNT_W'(MAX_FETCH));

   p_attr_col_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (load && cfg_attr_en) |-> (int'(rd_idx) < BUF_DEPTH));

   p_last_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (at_last && !load && !line_start) |=> !pix_active);

endmodule

// File: tb/test_attr_pixel_serializer.sv
module test_attr_pixel_serializer;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       line_start;
   logic [2:0] char_row;
   logic [1:0] cfg_scale;
   logic       cfg_attr_en;
   logic       cfg_attr_shared;
   logic       in_valid;
   logic       in_tag;
   logic [7:0] in_data;
   logic [3:0] pix_colour;
   logic       pix_active;

   attr_pixel_serializer i_attr_pixel_serializer (
      .clk             (clk),
      .rst_n           (rst_n),
      .line_start      (line_start),
      .char_row        (char_row),
      .cfg_scale       (cfg_scale),
      .cfg_attr_en     (cfg_attr_en),
      .cfg_attr_shared (cfg_attr_shared),
      .in_valid        (in_valid),
      .in_tag          (in_tag),
      .in_data         (in_data),
      .pix_colour      (pix_colour),
      .pix_active      (pix_active)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   // {scale code, bitmap byte} in plain mode
   localparam logic [9:0] VEC [0:5] = '{
      {2'd0, 8'hA5}, {2'd1, 8'h3C}, {2'd2, 8'h81},
      {2'd0, 8'hFF}, {2'd1, 8'h00}, {2'd2, 8'h5A}
   };

   task automatic check(input string req, input logic [3:0] exp_c, input logic exp_a);
      n_chk++;
      if (pix_colour !== exp_c || pix_active !== exp_a) begin
         n_err++;
         $display("FAIL %s: colour=%h active=%b expected colour=%h active=%b",
                  req, pix_colour, pix_active, exp_c, exp_a);
      end
   endtask

   task automatic start_line(input logic [2:0] row);
      @(negedge clk);
      line_start = 1'b1;
      char_row   = row;
      @(negedge clk);
      line_start = 1'b0;
   endtask

   task automatic send_attr(input logic [7:0] a);
      in_valid = 1'b1; in_tag = 1'b1; in_data = a;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // precondition: at a negedge; bitmap is taken at the next posedge
   task automatic feed(input logic [7:0] bm, input logic [7:0] at,
                       input logic inj, input logic [7:0] ia, input string req);
      int s;
      logic b;
      logic [3:0] e;
      s = int'(cfg_scale) + 1;
      in_valid = 1'b1; in_tag = 1'b0; in_data = bm;
      @(negedge clk);
      in_valid = 1'b0;
      for (int k = 0; k < 8*s; k++) begin
         b = bm[7 - k/s];
         if (cfg_attr_en) e = b ? at[7:4] : at[3:0];
         else             e = b ? 4'hF : 4'h8;
         check(req, e, 1'b1);
         if (inj && k == 3) begin
            in_valid = 1'b1; in_tag = 1'b1; in_data = ia;
         end else if (inj && k == 4) begin
            in_valid = 1'b0;
         end
         if (k < 8*s - 1) @(negedge clk);
      end
   endtask

   initial begin
      #(CLK_PERIOD*200000);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: run did not complete");
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; line_start = 1'b0; char_row = 3'd0; cfg_scale = 2'd0;
      cfg_attr_en = 1'b0; cfg_attr_shared = 1'b0;
      in_valid = 1'b0; in_tag = 1'b0; in_data = 8'h00;
      repeat (3) @(negedge clk);
      check("R1 in reset", 4'h0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", 4'h0, 1'b0);

      // table walk: plain mode, every scale code
      for (int i = 0; i < 6; i++) begin
         cfg_scale = VEC[i][9:8];
         start_line(3'd0);
         check("R5 blank after line start", 4'h0, 1'b0);
         feed(VEC[i][7:0], 8'h00, 1'b0, 8'h00, "R2 R3 R4 serial order");
         @(negedge clk);
         check("R3 blank after 8 pixels", 4'h0, 1'b0);
      end

      // back-to-back reload, x2
      cfg_scale = 2'd1;
      start_line(3'd0);
      feed(8'hC5, 8'h00, 1'b0, 8'h00, "R3 first byte");
      feed(8'h3A, 8'h00, 1'b0, 8'h00, "R3 seamless reload");
      @(negedge clk);
      check("R3 drain", 4'h0, 1'b0);

      // line start aborts a byte and drops a same-cycle byte
      cfg_scale = 2'd0;
      start_line(3'd0);
      in_valid = 1'b1; in_tag = 1'b0; in_data = 8'hFF;
      @(negedge clk);
      in_valid = 1'b0;
      check("R2 first pixel", 4'hF, 1'b1);
      @(negedge clk);
      line_start = 1'b1; in_valid = 1'b1; in_data = 8'hFF;
      @(negedge clk);
      line_start = 1'b0; in_valid = 1'b0;
      check("R5 abort", 4'h0, 1'b0);
      @(negedge clk);
      check("R5 same-cycle byte dropped", 4'h0, 1'b0);

      // attribute mode, unshared, first row
      cfg_scale = 2'd1; cfg_attr_en = 1'b1; cfg_attr_shared = 1'b0;
      start_line(3'd0);
      send_attr(8'h3C);
      check("R7 leading column blank", 4'h0, 1'b0);
      feed(8'hF0, 8'h3C, 1'b1, 8'h5A, "R6 R7 column 0");
      feed(8'h0F, 8'h5A, 1'b0, 8'h00, "R6 R7 column 1");
      @(negedge clk);
      check("R7 drain", 4'h0, 1'b0);

      // later row: attribute bytes ignored, buffer reused
      start_line(3'd1);
      send_attr(8'hEE);
      check("R8 attribute on later row shows nothing", 4'h0, 1'b0);
      feed(8'hF0, 8'h3C, 1'b1, 8'h77, "R8 column 0 reuses entry");
      feed(8'h96, 8'h5A, 1'b0, 8'h00, "R8 column 1 reuses entry");
      @(negedge clk);
      check("R8 drain", 4'h0, 1'b0);

      // shared attributes, first row
      cfg_attr_shared = 1'b1;
      start_line(3'd0);
      send_attr(8'h92);
      feed(8'hC3, 8'h92, 1'b0, 8'h00, "R9 column 0");
      feed(8'h3C, 8'h92, 1'b1, 8'h4D, "R9 column 1 shares entry 0");
      feed(8'hA6, 8'h4D, 1'b0, 8'h00, "R9 column 2 uses entry 1");
      @(negedge clk);
      check("R9 drain", 4'h0, 1'b0);

      // shared, later row, x3
      cfg_scale = 2'd2;
      start_line(3'd2);
      feed(8'h81, 8'h92, 1'b1, 8'h11, "R8 R9 row 2 column 0");
      feed(8'h7E, 8'h92, 1'b0, 8'h00, "R8 R9 row 2 column 1");
      feed(8'hF1, 8'h4D, 1'b0, 8'h00, "R8 R9 row 2 column 2");
      @(negedge clk);
      check("R3 drain x3", 4'h0, 1'b0);

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule